// File: doc/BRIEF.md
# Dual-Line Page Program Receiver

This block is the device-side front end of a serial flash for one write command, the page program with data on two lines. While chip select is low, it samples the serial clock with the system clock and counts rising serial-clock edges. The first 8 edges carry a command code on data line 0 and the next 24 carry the target address, most significant bit first. After that, every edge delivers two data bits, so one byte takes four edges. Each completed byte goes into a page buffer. Its position starts at the low address byte and advances, wrapping inside the page.

When chip select returns high, the block judges the whole frame. The frame must carry the program code and stop exactly after a whole data byte, with at least one byte sent. The write enable latch must be set, and the target address must lie outside the region selected by the protection inputs. A frame that passes starts a program cycle. The block pulses a start strobe, raises busy, clears the write enable latch and latches the address. The cycle is a counter of fixed length that a suspend request can freeze and a resume request can release. Status outputs stay valid the whole time, so a host can poll them.

Top module: `difp_rx`

## Requirements
- R1: After reset, busy, the start strobe, the suspended flag and the write enable latch are all 0.
- R2: A frame's command code is the first 8 bits on dq0, MSB first, and its address is the next 24 bits on dq0, bit 23 first. The address of a started program appears on prog_addr in the same cycle as the start strobe.
- R3: From serial edge 32 on, each edge carries two bits of a data byte: dq1 the odd bit, dq0 the even bit, bit pair 7/6 first and 1/0 last. Each completed byte is written to the page buffer at once whenever the frame began while idle and carries code 8'hA2. The rd_ofs/rd_byte port reads the buffer combinationally.
- R4: The first byte lands at the offset given by address bits 7:0. Each later byte goes to the next offset, and offset 255 is followed by offset 0.
- R5: When chip select rises after a valid frame, the start strobe is high for exactly one cycle in the second clock cycle after chip select is first sampled high. Busy rises in that same cycle and the write enable latch reads 0.
- R6: If chip select rises in the code or address phase, in the middle of a data byte, or before any data byte has completed, no program starts. Busy stays 0 and the write enable latch keeps its value.
- R7: A frame that ends while the write enable latch is 0 starts no program. The latch is set by a one-cycle wel_set pulse.
- R8: Protection uses 64 KiB blocks (address bits 23:16). With level n = prot_bp: 0 protects nothing, and n of 1 or more protects min(2^(n-1), 256) blocks. These blocks are the highest ones when prot_tb = 0 and the lowest ones when prot_tb = 1. A frame aimed at a protected block starts nothing.
- R9: Without suspension, busy stays high for exactly PROG_CYCLES clock cycles.
- R10: A susp_req pulse while busy sets the suspended flag and stops the cycle counter, with busy held high. A resume_req pulse clears the flag. The total busy time grows by one cycle for every cycle from the suspend pulse through the resume pulse.
- R11: A frame whose chip select falls while busy is ignored completely. No byte is written, no second start occurs and prog_addr is unchanged.
- R12: A frame carrying any code other than 8'hA2 writes nothing to the buffer and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by clk |
| dq0 | input | 1 | Data line 0: code, address, even data bits |
| dq1 | input | 1 | Data line 1: odd data bits |
| prot_bp | input | 4 | Protection level |
| prot_tb | input | 1 | Protected region at the bottom (1) or the top (0) |
| wel_set | input | 1 | Sets the write enable latch |
| susp_req | input | 1 | Suspend pulse |
| resume_req | input | 1 | Resume pulse |
| rd_ofs | input | 8 | Page buffer read offset |
| rd_byte | output | 8 | Page buffer byte at rd_ofs |
| prog_addr | output | 24 | Address of the last started program |
| prog_start | output | 1 | One-cycle start strobe |
| busy | output | 1 | Program cycle in progress |
| suspended | output | 1 | Program cycle paused |
| wel | output | 1 | Write enable latch |

## Verification
A slip in the edge or pair counter changes the frame-shape verdict. It shows up two clock cycles after chip select rises, as a start strobe that should or should not be there. A wrong buffer offset or bit order shows up at the read port as soon as the byte completes, and the bench catches it by reading back all 256 offsets. A fault in the run counter or the suspend logic changes the width of busy, and the bench counts that width cycle by cycle against PROG_CYCLES plus the suspended span.

// File: rtl/difp_pkg.sv
package difp_pkg;

    localparam int ADDR_W = 24;
    localparam int PAGE_BYTES_D = 256;
    localparam int BLK_SHIFT_D = 16;
    localparam int PROG_CYCLES_D = 4096;
    localparam logic [7:0] OPCODE_D = 8'hA2;
    localparam int CODE_BITS = 8;

    typedef enum logic [1:0] {
        PH_CODE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic              shape_ok;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    // Region test: blocks of 2^blk_shift bytes, level bp selects how many
    function automatic logic prot_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [3:0] bp,
                                      input logic tb,
                                      input int blk_shift);
        int unsigned nb_bits;
        int unsigned nblk;
        int unsigned blk;
        int unsigned cnt;
        nb_bits = ADDR_W - blk_shift;
        nblk    = 1 << nb_bits;
        blk     = 32'(addr) >> blk_shift;
        if (bp == 4'd0)
            cnt = 0;
        else if (int'(bp) - 1 >= int'(nb_bits))
            cnt = nblk;
        else
            cnt = 1 << (bp - 4'd1);
        return tb ? (blk < cnt) : (blk >= nblk - cnt);
    endfunction

endpackage

// File: rtl/difp_serial_in.sv
module difp_serial_in
    import difp_pkg::*;
#(
    parameter int PAGE_BYTES = PAGE_BYTES_D,
    parameter logic [7:0] OPCODE = OPCODE_D
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          sclk,
    input  logic                          dq0,
    input  logic                          dq1,
    input  logic                          idle,
    output logic                          wr_en,
    output logic [$clog2(PAGE_BYTES)-1:0] wr_ofs,
    output logic [7:0]                    wr_byte,
    output logic                          frame_end,
    output frame_t                        frame
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam logic [4:0] CODE_LAST = 5'(CODE_BITS - 1);
    localparam logic [4:0] ADDR_LAST = 5'(ADDR_W - 1);

    logic              cs_q, sclk_q, in_frame, accept, code_ok, got_byte;
    phase_e            phase;
    logic [4:0]        hdr_cnt;
    logic [7:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        pair_cnt;
    logic [5:0]        part_q;
    logic [OFS_W-1:0]  ofs;

    logic cs_fall, cs_rise, edge_hit;
    assign cs_fall  = cs_q & ~cs_n;
    assign cs_rise  = ~cs_q & cs_n;
    assign edge_hit = in_frame & ~cs_n & sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q      <= 1'b1;
            sclk_q    <= 1'b0;
            in_frame  <= 1'b0;
            accept    <= 1'b0;
            code_ok   <= 1'b0;
            got_byte  <= 1'b0;
            phase     <= PH_CODE;
            hdr_cnt   <= '0;
            code_q    <= '0;
            addr_q    <= '0;
            pair_cnt  <= '0;
            part_q    <= '0;
            ofs       <= '0;
            wr_en     <= 1'b0;
            wr_ofs    <= '0;
            wr_byte   <= '0;
            frame_end <= 1'b0;
            frame     <= '0;
        end else begin
            cs_q      <= cs_n;
            sclk_q    <= sclk;
            wr_en     <= 1'b0;
            frame_end <= 1'b0;
            if (cs_fall) begin
                in_frame <= 1'b1;
                accept   <= idle;
                code_ok  <= 1'b0;
                got_byte <= 1'b0;
                phase    <= PH_CODE;
                hdr_cnt  <= '0;
                pair_cnt <= '0;
            end else if (cs_rise && in_frame) begin
                in_frame       <= 1'b0;
                frame_end      <= 1'b1;
                frame.shape_ok <= accept && code_ok && (phase == PH_DATA)
                                  && (pair_cnt == 2'd0) && got_byte;
                frame.addr     <= addr_q;
            end else if (edge_hit) begin
                unique case (phase)
                    PH_CODE: begin
                        code_q <= {code_q[6:0], dq0};
                        if (hdr_cnt == CODE_LAST) begin
                            code_ok <= ({code_q[6:0], dq0} == OPCODE);
                            phase   <= PH_ADDR;
                            hdr_cnt <= '0;
                        end else begin
                            hdr_cnt <= hdr_cnt + 5'd1;
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= {addr_q[ADDR_W-2:0], dq0};
                        if (hdr_cnt == ADDR_LAST) begin
                            ofs     <= {addr_q[OFS_W-2:0], dq0};
                            phase   <= PH_DATA;
                            hdr_cnt <= '0;
                        end else begin
                            hdr_cnt <= hdr_cnt + 5'd1;
                        end
                    end
                    default: begin
                        part_q   <= {part_q[3:0], dq1, dq0};
                        pair_cnt <= pair_cnt + 2'd1;
                        if (pair_cnt == 2'd3) begin
                            wr_en    <= accept & code_ok;
                            wr_byte  <= {part_q, dq1, dq0};
                            wr_ofs   <= ofs;
                            ofs      <= ofs + 1'b1;
                            got_byte <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R3: buffer writes come only out of the data phase
    p_write_in_data_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> phase == PH_DATA);

    // R5: frame verdict is a single-cycle event
    p_frame_end_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    // R11: a frame opened while busy never writes
    p_busy_frame_silent_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> accept);

endmodule

// File: rtl/difp_page_buf.sv
module difp_page_buf
    import difp_pkg::*;
#(
    parameter int PAGE_BYTES = PAGE_BYTES_D
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0] wr_ofs,
    input  logic [7:0]                    wr_byte,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_ofs,
    output logic [7:0]                    rd_byte
);
    logic [7:0] mem [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ofs] <= wr_byte;
    end

    assign rd_byte = mem[rd_ofs];

endmodule

// File: rtl/difp_prog_ctl.sv
module difp_prog_ctl
    import difp_pkg::*;
#(
    parameter int PROG_CYCLES = PROG_CYCLES_D,
    parameter int BLK_SHIFT = BLK_SHIFT_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  frame_t            frame,
    input  logic [3:0]        prot_bp,
    input  logic              prot_tb,
    input  logic              wel_set,
    input  logic              susp_req,
    input  logic              resume_req,
    output logic              prog_start,
    output logic              busy,
    output logic              suspended,
    output logic              wel,
    output logic [ADDR_W-1:0] prog_addr
);
    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             guarded, go;

    assign guarded = prot_hit(frame.addr, prot_bp, prot_tb, BLK_SHIFT);
    assign go      = frame_end & frame.shape_ok & wel & ~busy & ~guarded;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_start <= 1'b0;
            busy       <= 1'b0;
            suspended  <= 1'b0;
            wel        <= 1'b0;
            prog_addr  <= '0;
            run_cnt    <= '0;
        end else begin
            prog_start <= 1'b0;
            if (go) begin
                prog_start <= 1'b1;
                busy       <= 1'b1;
                suspended  <= 1'b0;
                wel        <= 1'b0;
                prog_addr  <= frame.addr;
                run_cnt    <= '0;
            end else begin
                if (wel_set)
                    wel <= 1'b1;
                if (busy) begin
                    if (suspended) begin
                        if (resume_req)
                            suspended <= 1'b0;
                    end else if (susp_req) begin
                        suspended <= 1'b1;
                    end else if (run_cnt == LAST) begin
                        busy    <= 1'b0;
                        run_cnt <= '0;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R5: strobe lasts one cycle, raises busy, drops the latch
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> !prog_start);
    p_busy_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> prog_start);
    p_wel_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> !wel);

    // R6: a start needs a frame verdict from the receiver one cycle earlier
    p_start_needs_frame_r6: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(frame_end));

    // R9: an active run does not stop before its last count
    p_run_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !suspended && !susp_req && run_cnt != LAST) |=> busy);

    // R10: a paused run keeps busy and its count
    p_pause_holds_r10: assert property (@(posedge clk) disable iff (rst)
        suspended |=> busy && $stable(run_cnt));

    // R11: no restart while a run is going on
    p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> !prog_start);

endmodule

// File: rtl/difp_rx.sv
module difp_rx
    import difp_pkg::*;
#(
    parameter int PAGE_BYTES = PAGE_BYTES_D,
    parameter int BLK_SHIFT = BLK_SHIFT_D,
    parameter int PROG_CYCLES = PROG_CYCLES_D,
    parameter logic [7:0] OPCODE = OPCODE_D
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          sclk,
    input  logic                          dq0,
    input  logic                          dq1,
    input  logic [3:0]                    prot_bp,
    input  logic                          prot_tb,
    input  logic                          wel_set,
    input  logic                          susp_req,
    input  logic                          resume_req,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_ofs,
    output logic [7:0]                    rd_byte,
    output logic [ADDR_W-1:0]             prog_addr,
    output logic                          prog_start,
    output logic                          busy,
    output logic                          suspended,
    output logic                          wel
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic             wr_en;
    logic [OFS_W-1:0] wr_ofs;
    logic [7:0]       wr_byte;
    logic             frame_end;
    frame_t           frame;

    difp_serial_in #(
        .PAGE_BYTES(PAGE_BYTES),
        .OPCODE    (OPCODE)
    ) u_serial (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .dq0      (dq0),
        .dq1      (dq1),
        .idle     (~busy),
        .wr_en    (wr_en),
        .wr_ofs   (wr_ofs),
        .wr_byte  (wr_byte),
        .frame_end(frame_end),
        .frame    (frame)
    );

    difp_page_buf #(
        .PAGE_BYTES(PAGE_BYTES)
    ) u_buf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_ofs (wr_ofs),
        .wr_byte(wr_byte),
        .rd_ofs (rd_ofs),
        .rd_byte(rd_byte)
    );

    difp_prog_ctl #(
        .PROG_CYCLES(PROG_CYCLES),
        .BLK_SHIFT  (BLK_SHIFT)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .frame     (frame),
        .prot_bp   (prot_bp),
        .prot_tb   (prot_tb),
        .wel_set   (wel_set),
        .susp_req  (susp_req),
        .resume_req(resume_req),
        .prog_start(prog_start),
        .busy      (busy),
        .suspended (suspended),
        .wel       (wel),
        .prog_addr (prog_addr)
    );

endmodule

// File: tb/difp_rx_tb.sv
`timescale 1ns/1ps
module difp_rx_tb;
    localparam int P = 40;
    localparam int K = 60;

    logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, dq0 = 1'b0, dq1 = 1'b0;
    logic prot_tb = 1'b0, wel_set = 1'b0, susp_req = 1'b0, resume_req = 1'b0;
    logic [3:0]  prot_bp = 4'd0;
    logic [7:0]  rd_ofs = 8'd0;
    logic [7:0]  rd_byte;
    logic [23:0] prog_addr;
    logic        prog_start, busy, suspended, wel;

    int   vecs = 0, errs = 0;
    bit   finished = 1'b0;
    logic [7:0] exp_buf [256];

    difp_rx #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .dq0(dq0), .dq1(dq1),
        .prot_bp(prot_bp), .prot_tb(prot_tb), .wel_set(wel_set),
        .susp_req(susp_req), .resume_req(resume_req), .rd_ofs(rd_ofs),
        .rd_byte(rd_byte), .prog_addr(prog_addr), .prog_start(prog_start),
        .busy(busy), .suspended(suspended), .wel(wel)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(int'(seed) + i * 37 + (i >> 3));
    endfunction

    function automatic bit exp_prot(input logic [23:0] a, input int bp, input bit tb);
        int blk, cnt;
        blk = int'(a[23:16]);
        if (bp == 0) cnt = 0;
        else if (bp - 1 >= 8) cnt = 256;
        else cnt = 1 << (bp - 1);
        return tb ? (blk < cnt) : (blk >= 256 - cnt);
    endfunction

    task automatic tick(input logic b0, input logic b1);
        sclk = 1'b0; dq0 = b0; dq1 = b1;
        @(negedge clk);
        sclk = 1'b1;
        @(negedge clk);
    endtask

    // Sends one frame and raises chip select; returns at the negedge two cycles later
    task automatic frame(input logic [7:0] code, input logic [23:0] addr, input int hdr_bits,
                         input int nbytes, input int extra, input logic [7:0] seed, input bit model);
        cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < hdr_bits; i++)
            tick(i < 8 ? code[7-i] : addr[23-(i-8)], 1'b0);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] b;
            b = pat(seed, i);
            for (int p = 0; p < 4; p++)
                tick(b[6-2*p], b[7-2*p]);
            if (model) exp_buf[8'(addr[7:0] + 8'(i))] = b;
        end
        for (int i = 0; i < extra; i++)
            tick(1'b1, 1'b0);
        sclk = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic pulse_wel();
        wel_set = 1'b1;
        @(negedge clk);
        wel_set = 1'b0;
    endtask

    task automatic busy_width(output int n);
        n = 0;
        while (busy && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_buf(input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < 256; k++) begin
            rd_ofs = 8'(k);
            #0.1;
            if (rd_byte !== exp_buf[k]) begin
                if (bad == 0)
                    $display("FAIL %s offset %0d actual=%0h expected=%0h", tag, k, rd_byte, exp_buf[k]);
                bad++;
            end
        end
        vecs++;
        if (bad != 0) errs++;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int n;
        logic [23:0] keep_addr;
        logic [23:0] sweep [6];
        sweep[0] = 24'h000000; sweep[1] = 24'h01ABCD; sweep[2] = 24'h7F0010;
        sweep[3] = 24'h80FF00; sweep[4] = 24'hFE0001; sweep[5] = 24'hFFFF00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 start", prog_start, 0);
        chk("R1 suspended", suspended, 0);
        chk("R1 wel", wel, 0);

        // Fill the whole page once so the buffer model is fully known (R3, R4)
        pulse_wel();
        prot_bp = 4'd0;
        frame(8'hA2, 24'h000000, 32, 256, 0, 8'h11, 1);
        chk("R5 start after full page", prog_start, 1);
        busy_width(n);
        chk("R9 busy width", n, P);
        check_buf("R3 full page");

        // R2, R5: normal command
        pulse_wel();
        chk("R7 wel set", wel, 1);
        frame(8'hA2, 24'h123405, 32, 4, 0, 8'h5A, 1);
        chk("R5 start", prog_start, 1);
        chk("R5 busy", busy, 1);
        chk("R5 wel cleared", wel, 0);
        chk("R2 prog_addr", prog_addr, 24'h123405);
        @(negedge clk);
        chk("R5 start one cycle", prog_start, 0);
        busy_width(n);
        chk("R9 busy width", n, P - 1);
        check_buf("R3 four bytes at offset 5");

        // R7: latch clear
        frame(8'hA2, 24'h223344, 32, 2, 0, 8'h77, 1);
        chk("R7 no start", prog_start, 0);
        chk("R7 no busy", busy, 0);

        // R4: wrap past the page end
        pulse_wel();
        frame(8'hA2, 24'h0400FA, 32, 260, 0, 8'h3C, 1);
        chk("R4 start", prog_start, 1);
        busy_width(n);
        check_buf("R4 wrap");

        // R6: misaligned endings
        pulse_wel();
        frame(8'hA2, 24'h050000, 32, 2, 1, 8'h90, 1);
        chk("R6 mid byte no start", prog_start, 0);
        chk("R6 mid byte busy", busy, 0);
        chk("R6 wel kept", wel, 1);
        frame(8'hA2, 24'h050000, 32, 1, 3, 8'h91, 1);
        chk("R6 three pairs no start", prog_start, 0);
        frame(8'hA2, 24'h050000, 32, 0, 0, 8'h00, 0);
        chk("R6 zero bytes no start", prog_start, 0);
        frame(8'hA2, 24'h050000, 20, 0, 0, 8'h00, 0);
        chk("R6 in address no start", prog_start, 0);
        frame(8'hA2, 24'h050000, 5, 0, 0, 8'h00, 0);
        chk("R6 in code no start", prog_start, 0);
        chk("R6 wel still set", wel, 1);
        check_buf("R6 buffer");

        // R12: other code
        frame(8'h02, 24'h0600C0, 32, 3, 0, 8'hE1, 0);
        chk("R12 no start", prog_start, 0);
        chk("R12 no busy", busy, 0);
        check_buf("R12 buffer untouched");

        // R11: frame opened during busy
        pulse_wel();
        frame(8'hA2, 24'h002010, 32, 2, 0, 8'h44, 1);
        chk("R11 first start", prog_start, 1);
        keep_addr = prog_addr;
        pulse_wel();
        frame(8'hA2, 24'h330080, 32, 3, 0, 8'hB7, 0);
        chk("R11 no second start", prog_start, 0);
        chk("R11 prog_addr kept", prog_addr, keep_addr);
        chk("R11 idle", busy, 0);
        check_buf("R11 buffer untouched");

        // R10: suspend and resume
        pulse_wel();
        frame(8'hA2, 24'h010203, 32, 1, 0, 8'h21, 1);
        chk("R10 start", prog_start, 1);
        n = 0;
        for (int j = 0; j < 1000 && busy; j++) begin
            n++;
            if (j == 5) susp_req = 1'b1;
            if (j == 6) susp_req = 1'b0;
            if (j == 6 + K / 2) begin
                chk("R10 suspended flag", suspended, 1);
                chk("R10 busy held", busy, 1);
            end
            if (j == 6 + K) resume_req = 1'b1;
            if (j == 7 + K) resume_req = 1'b0;
            if (j == 9 + K) chk("R10 resumed", suspended, 0);
            @(negedge clk);
        end
        chk("R10 busy width with pause", n, P + K + 2);

        // R8: protection sweep
        for (int bp = 0; bp < 16; bp++) begin
            for (int tb = 0; tb < 2; tb++) begin
                for (int a = 0; a < 6; a++) begin
                    bit hit;
                    prot_bp = 4'(bp);
                    prot_tb = tb[0];
                    hit = exp_prot(sweep[a], bp, tb[0]);
                    pulse_wel();
                    frame(8'hA2, sweep[a], 32, 1, 0, 8'(bp * 16 + a), 1);
                    vecs++;
                    if (prog_start !== !hit) begin
                        errs++;
                        $display("FAIL R8 bp=%0d tb=%0d addr=%0h actual=%0b expected=%0b",
                                 bp, tb, sweep[a], prog_start, !hit);
                    end
                    if (prog_start) busy_width(n);
                end
            end
        end
        check_buf("R8 buffer");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule